// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block divides a stream of input ticks by a software-chosen divisor and raises an interrupt request once per period. Its intended use is timing-critical work such as stepping an event sequencer. Software sets the divisor to a fixed multiple of the tempo rate, for example 128 or 256 times the beat rate. A tempo change is then a single divisor write. Software arms the timer when playback or recording begins and disarms it when they end.

The count is deterministic when the divisor is rewritten. A divisor write always reloads the live count with the new value. The count therefore never runs past a smaller new limit and never wraps. A divisor of zero marks the timer as free and holds it idle. A separate elapsed-tick counter runs on every input tick and software can only read it. It does not depend on arming, masking or the pending flag.

The register port is a plain synchronous port. A write takes effect on the clock edge where `wr_en` is high. A read issued with `rd_en` returns data on `rdata` in the next cycle, marked by `rd_valid`. The port has no back-pressure: every request completes in one cycle.

Top module: `prog_tick_timer`

## Requirements
- R1: After reset, the divisor, arm and enable bits, pending flag, live count and elapsed count all read as zero, and `irq` is low.
- R2: A write to the divisor register (address 0, bits 11:0) loads the live count with the written value on the same edge, whatever the count held before. The count never counts past the new value and never wraps.
- R3: While the divisor is zero, the live count stays at zero and the pending flag is never set, even when the timer is armed.
- R4: When armed with divisor N (1 to 4095), the N-th input tick after a load sets the pending flag and reloads the live count with N on that same edge.
- R5: Control register (address 1): bit 0 is arm. Writing arm=1 while disarmed loads the live count from the divisor. While disarmed, the live count is frozen and the pending flag is not set.
- R6: The pending flag (address 1, bit 2) stays set until a control write has bit 2 equal to 1. A control write with bit 2 equal to 0 leaves it unchanged.
- R7: If the terminal tick and a pending-clear write fall on the same edge, the pending flag stays set.
- R8: `irq` equals pending AND interrupt enable (address 1, bit 1). Clearing the enable masks `irq` only; counting and the pending flag continue.
- R9: The elapsed counter (address 3) adds one on every input tick, whatever the state of arm, enable, pending and divisor. Writes to address 3 have no effect.
- R10: A read with `rd_en` at address A sets `rd_valid` and presents the register value on `rdata` one cycle later. Address 2 returns the live count.
- R11: When a divisor write and an input tick fall on the same edge, the write wins: the count takes the written value, no terminal event occurs, and the elapsed counter still advances.
- R12: The largest divisor, 4095, produces pending exactly on the 4095th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle input tick from the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest situations to bring about are two events on the same edge. One is a terminal tick that meets a pending-clear write. The other is a divisor write that meets an input tick. The bench drives the tick strobe and the bus write in the same cycle, after counting the live count down to exactly 1 through register reads. The bench also reaches the 4095 boundary by streaming 4094 ticks back-to-back. It then confirms that the count sits at 1 with nothing pending before it issues the final tick.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  typedef enum logic [1:0] {
    REG_DIV     = 2'd0,
    REG_CTRL    = 2'd1,
    REG_COUNT   = 2'd2,
    REG_ELAPSED = 2'd3
  } ptt_reg_e;

  localparam int CTRL_ARM  = 0;
  localparam int CTRL_IEN  = 1;
  localparam int CTRL_PEND = 2;
endpackage

// File: rtl/ptt_countdown.sv
module ptt_countdown #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] div,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tc
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic active;
  assign active = tick && run && (div != '0) && !load;
  assign tc     = active && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (tc)     cnt <= div;
    else if (active) cnt <= cnt - ONE;
  end
endmodule

// File: rtl/ptt_elapsed.sv
module ptt_elapsed #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (tick) value <= value + W'(1);
  end
endmodule

// File: rtl/ptt_regfile.sv
module ptt_regfile
  import ptt_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int ELAPSED_W = 16,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [ELAPSED_W-1:0] elapsed,
  input  logic                 tc,
  output logic [CNT_W-1:0]     div_q,
  output logic                 run_q,
  output logic                 ien_q,
  output logic                 pend_q,
  output logic                 div_wr,
  output logic                 arm_rise,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rd_valid
);
  logic ctrl_wr;
  logic [DATA_W-1:0] rd_mux;

  assign div_wr   = wr_en && (addr == REG_DIV);
  assign ctrl_wr  = wr_en && (addr == REG_CTRL);
  assign arm_rise = ctrl_wr && wdata[CTRL_ARM] && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (div_wr) div_q <= wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        run_q <= wdata[CTRL_ARM];
        ien_q <= wdata[CTRL_IEN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          pend_q <= 1'b0;
    else if (tc)                         pend_q <= 1'b1;
    else if (ctrl_wr && wdata[CTRL_PEND]) pend_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (ptt_reg_e'(addr))
      REG_DIV:     rd_mux = DATA_W'(div_q);
      REG_CTRL: begin
        rd_mux[CTRL_ARM]  = run_q;
        rd_mux[CTRL_IEN]  = ien_q;
        rd_mux[CTRL_PEND] = pend_q;
      end
      REG_COUNT:   rd_mux = DATA_W'(cnt);
      REG_ELAPSED: rd_mux = DATA_W'(elapsed);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/prog_tick_timer.sv
module prog_tick_timer #(
  parameter int CNT_W     = 12,
  parameter int ELAPSED_W = 16,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              irq
);
  logic [CNT_W-1:0]     div_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     load_val;
  logic [ELAPSED_W-1:0] elapsed_q;
  logic run_q, ien_q, pend_q, div_wr, arm_rise, tc;

  assign load_val = div_wr ? wdata[CNT_W-1:0] : div_q;
  assign irq      = pend_q && ien_q;

  ptt_regfile #(.CNT_W(CNT_W), .ELAPSED_W(ELAPSED_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt_q), .elapsed(elapsed_q), .tc(tc),
    .div_q(div_q), .run_q(run_q), .ien_q(ien_q), .pend_q(pend_q),
    .div_wr(div_wr), .arm_rise(arm_rise), .rdata(rdata), .rd_valid(rd_valid)
  );

  ptt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .run(run_q), .div(div_q),
    .load(div_wr || arm_rise), .load_val(load_val), .cnt(cnt_q), .tc(tc)
  );

  ptt_elapsed #(.W(ELAPSED_W)) u_elapsed (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .value(elapsed_q)
  );
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int CNT_W     = 12,
  parameter int ELAPSED_W = 16,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 wr_en,
  input logic [1:0]           addr,
  input logic [DATA_W-1:0]    wdata,
  input logic                 irq,
  input logic [CNT_W-1:0]     cnt,
  input logic [CNT_W-1:0]     div,
  input logic                 run,
  input logic                 pend,
  input logic                 tc,
  input logic [ELAPSED_W-1:0] elapsed
);
  // R2
  div_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> cnt == $past(wdata[CNT_W-1:0]));

  // R3
  idle_no_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |-> !tc);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div != '0) |-> (cnt != '0 && cnt <= div));

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(wr_en && addr == 2'd1 && wdata[2])) |=> pend);

  // R7
  tc_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> pend);

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  // R9
  elapsed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> elapsed == ELAPSED_W'($past(elapsed) + 1'b1));

  // R9
  elapsed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(elapsed));
endmodule

bind prog_tick_timer ptt_checker #(.CNT_W(CNT_W), .ELAPSED_W(ELAPSED_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .cnt(cnt_q), .div(div_q), .run(run_q),
  .pend(pend_q), .tc(tc), .elapsed(elapsed_q)
);

// File: tb/prog_tick_timer_test.sv
module prog_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  int ticks = 0;
  int cycles = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  prog_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 16'd1, 16'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic tk);
    wr_en = 1'b1; addr = a; wdata = d; tick_en = tk;
    if (tk) ticks++;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1; ticks++;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq after reset", 16'(irq), 16'd0);
    bus_rd(2'd0, 16'd0, "R1 divisor reset");
    bus_rd(2'd1, 16'd0, "R1 control reset");
    bus_rd(2'd2, 16'd0, "R1 count reset");
    bus_rd(2'd3, 16'd0, "R1 elapsed reset");
    // R2 load, R5 frozen while disarmed
    bus_wr(2'd0, 16'd5, 1'b0);
    bus_rd(2'd0, 16'd5, "R10 divisor readback");
    bus_rd(2'd2, 16'd5, "R2 count loaded");
    pulse(3);
    bus_rd(2'd2, 16'd5, "R5 frozen while disarmed");
    // R4 period with arm, R8 enabled irq
    bus_wr(2'd1, 16'b011, 1'b0);
    pulse(4);
    bus_rd(2'd2, 16'd1, "R4 count before terminal");
    check("R4 no irq before terminal", 16'(irq), 16'd0);
    pulse(1);
    check("R8 irq at terminal", 16'(irq), 16'd1);
    bus_rd(2'd1, 16'b111, "R4 pending set");
    bus_rd(2'd2, 16'd5, "R4 reload on terminal");
    // R6 sticky, W1C
    bus_wr(2'd1, 16'b011, 1'b0);
    check("R6 write zero keeps pending", 16'(irq), 16'd1);
    bus_wr(2'd1, 16'b111, 1'b0);
    check("R6 clear drops irq", 16'(irq), 16'd0);
    bus_rd(2'd1, 16'b011, "R6 pending cleared");
    // R8 mask
    bus_wr(2'd1, 16'b001, 1'b0);
    pulse(5);
    check("R8 masked irq low", 16'(irq), 16'd0);
    bus_rd(2'd1, 16'b101, "R8 pending still set when masked");
    // R2 mid-count rewrite up and down
    bus_wr(2'd1, 16'b101, 1'b0);
    pulse(2);
    bus_rd(2'd2, 16'd3, "R2 count mid run");
    bus_wr(2'd0, 16'd10, 1'b0);
    bus_rd(2'd2, 16'd10, "R2 rewrite larger");
    pulse(6);
    bus_rd(2'd2, 16'd4, "R2 count before shrink");
    bus_wr(2'd0, 16'd2, 1'b0);
    bus_rd(2'd2, 16'd2, "R2 rewrite smaller no wrap");
    pulse(2);
    bus_rd(2'd1, 16'b101, "R2 new period terminal");
    // R7 terminal and clear together
    bus_wr(2'd1, 16'b101, 1'b0);
    pulse(1);
    bus_rd(2'd1, 16'b001, "R7 cleared before race");
    bus_rd(2'd2, 16'd1, "R7 count at one");
    bus_wr(2'd1, 16'b101, 1'b1);
    bus_rd(2'd1, 16'b101, "R7 pending survives clear");
    bus_rd(2'd2, 16'd2, "R7 reload");
    // R11 divisor write vs tick
    bus_wr(2'd1, 16'b101, 1'b0);
    bus_wr(2'd0, 16'd7, 1'b1);
    bus_rd(2'd2, 16'd7, "R11 write wins over tick");
    bus_rd(2'd1, 16'b001, "R11 no terminal");
    // R5 disarm freezes, re-arm reloads
    pulse(3);
    bus_wr(2'd1, 16'b000, 1'b0);
    pulse(10);
    bus_rd(2'd2, 16'd4, "R5 frozen after disarm");
    bus_rd(2'd1, 16'b000, "R5 no pending while disarmed");
    bus_wr(2'd1, 16'b001, 1'b0);
    bus_rd(2'd2, 16'd7, "R5 arm reloads");
    // R3 divisor zero
    bus_wr(2'd0, 16'd0, 1'b0);
    pulse(5);
    bus_rd(2'd2, 16'd0, "R3 count idle");
    bus_rd(2'd1, 16'b001, "R3 no pending");
    bus_rd(2'd0, 16'd0, "R3 divisor free");
    // R12 max divisor
    bus_wr(2'd0, 16'd4095, 1'b0);
    pulse(4094);
    bus_rd(2'd2, 16'd1, "R12 count at one");
    bus_rd(2'd1, 16'b001, "R12 not yet pending");
    pulse(1);
    bus_rd(2'd1, 16'b101, "R12 pending on 4095th");
    bus_rd(2'd2, 16'd4095, "R12 reload");
    check("R8 masked at max", 16'(irq), 16'd0);
    bus_wr(2'd1, 16'b011, 1'b0);
    check("R8 enable raises irq", 16'(irq), 16'd1);
    bus_wr(2'd1, 16'b111, 1'b0);
    check("R8 clear with enable", 16'(irq), 16'd0);
    // R9 elapsed
    bus_rd(2'd3, 16'(ticks), "R9 elapsed count");
    bus_wr(2'd3, 16'h1234, 1'b0);
    bus_rd(2'd3, 16'(ticks), "R9 write ignored");
    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule